// File: doc/BRIEF.md
# Threshold Path Request Header Generator

This block sits in the transmit side of a network interface that shares a time-slotted optical fabric. It watches how many cells are queued locally for each destination. When a destination's backlog reaches a fixed threshold, it marks a request for a dedicated circuit path to that destination. Once per round-robin cycle, when the slot counter enters the slot reserved for the central arbiter, it builds one control header. The header carries at most one pending request: the source node, the destination, the queued volume and a service-type code.

If the transmit path has a data cell ready for the arbiter slot, the header rides on that cell. If not, the header is flagged as an empty placeholder cell, so control information reaches the arbiter every cycle whether or not there is payload or a pending request. When several destinations are pending, they are reported one per cycle in round-robin order. A destination that has been reported is not requested again until its backlog falls below the threshold and then climbs back to it.

Top module: `prq_hdr_gen`

## Requirements
- R1: After reset `hdr_valid_o` is 0 and no destination is pending, so the first header produced carries no request.
- R2: A destination whose count has become greater than or equal to THRESHOLD at least one clock before the arbiter slot is entered is reported in that slot's header with the request bit set and the destination index in the dst field.
- R3: A count of THRESHOLD-1 or less never raises a request.
- R4: After a destination has been reported, it is not reported again while its count stays at or above THRESHOLD. It becomes eligible again only after the count drops below THRESHOLD and then reaches it again.
- R5: `hdr_valid_o` pulses for exactly one clock per round-robin cycle, one clock after the first clock in which `slot_i` equals ARB_SLOT, however long the slot counter stays at ARB_SLOT.
- R6: The header's empty flag is 1 when `data_valid_i` was 0 on the slot-entry clock, and 0 when it was 1.
- R7: A header is produced in every cycle even when nothing is pending. In that case the request bit is 0 and the dst and volume fields are 0.
- R8: With several destinations pending, the one chosen is the first pending index at or after the index following the last reported destination, wrapping from NUM_DEST-1 to 0.
- R9: Header layout, from MSB to LSB over 25 bits: empty [24], request [23], src [22:19] (= NODE_ID), dst [18:15], volume [14:3] (the destination's count on the slot-entry clock), service type [2:0] (the destination's service code).
- R10: A pending request whose count drops below THRESHOLD before it is reported is withdrawn and is not reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_flat_i | input | NUM_DEST*12 | Queued-cell count per destination; destination d in bits [d*12 +: 12] |
| svc_flat_i | input | NUM_DEST*3 | Service-type code per destination; destination d in bits [d*3 +: 3] |
| slot_i | input | SLOT_W | Current round-robin slot index, wrapping modulo NUM_SLOTS |
| data_valid_i | input | 1 | Transmit path has a data cell ready for the current slot |
| hdr_valid_o | output | 1 | One-clock strobe marking a new header |
| hdr_o | output | 25 | Control header, layout given in R9 |

## Verification
The hardest case to reach from the ports is the round-robin order across the wrap point. It needs several destinations pending at once while the pointer sits partway through the index range. The stimulus first reports a single middle destination to place the pointer, then raises three destinations on both sides of it and runs consecutive arbiter cycles, expecting the order to wrap. The other hard case is a request that is withdrawn before it is reported. Here the bench raises a count to the threshold, lowers it again before the slot counter reaches the arbiter slot, and expects a header with no request.

// File: rtl/prq_pkg.sv
package prq_pkg;
    localparam int NODE_W = 4;
    localparam int CNT_W  = 12;
    localparam int SVC_W  = 3;

    typedef struct packed {
        logic              empty;
        logic              req;
        logic [NODE_W-1:0] src;
        logic [NODE_W-1:0] dst;
        logic [CNT_W-1:0]  vol;
        logic [SVC_W-1:0]  svc;
    } prq_hdr_t;

    localparam int HDR_W = $bits(prq_hdr_t);

    // Next index after v in a ring of n entries
    function automatic logic [NODE_W-1:0] ring_next(logic [NODE_W-1:0] v, int n);
        int t;
        t = int'(v) + 1;
        if (t >= n) t = 0;
        return NODE_W'(t);
    endfunction
endpackage

// File: rtl/prq_thr_watch.sv
module prq_thr_watch
    import prq_pkg::*;
#(
    parameter int THRESHOLD = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count_i,
    input  logic             clear_i,
    output logic             pending_o
);
    logic above;
    logic latched;

    assign above = (count_i >= CNT_W'(THRESHOLD));

    always_ff @(posedge clk) begin
        if (rst) begin
            latched   <= 1'b0;
            pending_o <= 1'b0;
        end else if (!above) begin
            latched   <= 1'b0;
            pending_o <= 1'b0;
        end else if (!latched) begin
            latched   <= 1'b1;
            pending_o <= 1'b1;
        end else if (clear_i) begin
            pending_o <= 1'b0;
        end
    end
endmodule

// File: rtl/prq_rr_pick.sv
module prq_rr_pick
    import prq_pkg::*;
#(
    parameter int N = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      req_i,
    input  logic              advance_i,
    output logic [NODE_W-1:0] gnt_idx_o,
    output logic              gnt_any_o
);
    logic [NODE_W-1:0] ptr;

    always_comb begin
        int c;
        gnt_any_o = 1'b0;
        gnt_idx_o = '0;
        for (int i = 0; i < N; i++) begin
            c = int'(ptr) + i;
            if (c >= N) c = c - N;
            if (!gnt_any_o && req_i[c]) begin
                gnt_any_o = 1'b1;
                gnt_idx_o = NODE_W'(c);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (advance_i && gnt_any_o) begin
            ptr <= ring_next(gnt_idx_o, N);
        end
    end
endmodule

// File: rtl/prq_slot_entry.sv
module prq_slot_entry #(
    parameter int SLOT_W   = 3,
    parameter int ARB_SLOT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SLOT_W-1:0] slot_i,
    output logic              entry_o
);
    logic is_arb;
    logic in_arb;

    assign is_arb  = (slot_i == SLOT_W'(ARB_SLOT));
    assign entry_o = is_arb && !in_arb;

    always_ff @(posedge clk) begin
        if (rst) in_arb <= 1'b0;
        else     in_arb <= is_arb;
    end
endmodule

// File: rtl/prq_hdr_gen.sv
module prq_hdr_gen
    import prq_pkg::*;
#(
    parameter int NUM_DEST  = 6,
    parameter int THRESHOLD = 16,
    parameter int NUM_SLOTS = 5,
    parameter int ARB_SLOT  = 3,
    parameter int NODE_ID   = 2,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_DEST*CNT_W-1:0] cnt_flat_i,
    input  logic [NUM_DEST*SVC_W-1:0] svc_flat_i,
    input  logic [SLOT_W-1:0]         slot_i,
    input  logic                      data_valid_i,
    output logic                      hdr_valid_o,
    output logic [HDR_W-1:0]          hdr_o
);
    logic [CNT_W-1:0]  cnt_a [NUM_DEST];
    logic [SVC_W-1:0]  svc_a [NUM_DEST];
    logic [NUM_DEST-1:0] pending;
    logic [NUM_DEST-1:0] clear;
    logic              entry;
    logic [NODE_W-1:0] gnt_idx;
    logic              gnt_any;
    prq_hdr_t          hdr_d;
    prq_hdr_t          hdr_q;

    prq_slot_entry #(.SLOT_W(SLOT_W), .ARB_SLOT(ARB_SLOT)) u_entry (
        .clk(clk), .rst(rst), .slot_i(slot_i), .entry_o(entry)
    );

    for (genvar d = 0; d < NUM_DEST; d++) begin : g_dest
        assign cnt_a[d] = cnt_flat_i[d*CNT_W +: CNT_W];
        assign svc_a[d] = svc_flat_i[d*SVC_W +: SVC_W];
        assign clear[d] = entry && gnt_any && (gnt_idx == NODE_W'(d));

        prq_thr_watch #(.THRESHOLD(THRESHOLD)) u_watch (
            .clk(clk), .rst(rst), .count_i(cnt_a[d]),
            .clear_i(clear[d]), .pending_o(pending[d])
        );
    end

    prq_rr_pick #(.N(NUM_DEST)) u_pick (
        .clk(clk), .rst(rst), .req_i(pending), .advance_i(entry),
        .gnt_idx_o(gnt_idx), .gnt_any_o(gnt_any)
    );

    always_comb begin
        hdr_d       = '0;
        hdr_d.empty = !data_valid_i;
        hdr_d.src   = NODE_W'(NODE_ID);
        if (gnt_any) begin
            hdr_d.req = 1'b1;
            hdr_d.dst = gnt_idx;
            hdr_d.vol = cnt_a[gnt_idx];
            hdr_d.svc = svc_a[gnt_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_valid_o <= 1'b0;
            hdr_q       <= '0;
        end else begin
            hdr_valid_o <= entry;
            if (entry) hdr_q <= hdr_d;
        end
    end

    assign hdr_o = hdr_q;
endmodule

// File: rtl/prq_hdr_gen_chk.sv
module prq_hdr_gen_chk
    import prq_pkg::*;
#(
    parameter int NUM_DEST  = 6,
    parameter int THRESHOLD = 16,
    parameter int ARB_SLOT  = 3,
    parameter int NODE_ID   = 2,
    parameter int SLOT_W    = 3
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NUM_DEST*CNT_W-1:0] cnt_flat_i,
    input logic [SLOT_W-1:0]         slot_i,
    input logic                      data_valid_i,
    input logic                      hdr_valid_o,
    input logic [HDR_W-1:0]          hdr_o
);
    logic [NUM_DEST*CNT_W-1:0] cnt_q;
    logic [SLOT_W-1:0]         slot_q;
    logic                      dv_q;
    prq_hdr_t                  h;
    logic [CNT_W-1:0]          dst_cnt;

    always_ff @(posedge clk) begin
        cnt_q  <= cnt_flat_i;
        slot_q <= slot_i;
        dv_q   <= data_valid_i;
    end

    assign h       = prq_hdr_t'(hdr_o);
    assign dst_cnt = CNT_W'(cnt_q >> (int'(h.dst) * CNT_W));

    assert_after_arb_slot_R5: assert property (@(posedge clk) disable iff (rst)
        hdr_valid_o |-> slot_q == SLOT_W'(ARB_SLOT));
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        hdr_valid_o |=> !hdr_valid_o);
    assert_empty_flag_R6: assert property (@(posedge clk) disable iff (rst)
        hdr_valid_o |-> h.empty == !dv_q);
    assert_src_field_R9: assert property (@(posedge clk) disable iff (rst)
        hdr_valid_o |-> h.src == NODE_W'(NODE_ID));
    assert_req_at_threshold_R2: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid_o && h.req) |-> dst_cnt >= CNT_W'(THRESHOLD));
    assert_volume_R9: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid_o && h.req) |-> h.vol == dst_cnt);
    assert_idle_header_R7: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid_o && !h.req) |-> (h.dst == '0 && h.vol == '0));
endmodule

bind prq_hdr_gen prq_hdr_gen_chk #(
    .NUM_DEST(NUM_DEST), .THRESHOLD(THRESHOLD), .ARB_SLOT(ARB_SLOT),
    .NODE_ID(NODE_ID), .SLOT_W(SLOT_W)
) u_chk (
    .clk(clk), .rst(rst), .cnt_flat_i(cnt_flat_i), .slot_i(slot_i),
    .data_valid_i(data_valid_i), .hdr_valid_o(hdr_valid_o), .hdr_o(hdr_o)
);

// File: tb/test_prq_hdr_gen.sv
module test_prq_hdr_gen;
    import prq_pkg::*;

    localparam int NUM_DEST  = 6;
    localparam int THRESHOLD = 16;
    localparam int NUM_SLOTS = 5;
    localparam int ARB_SLOT  = 3;
    localparam int NODE_ID   = 2;
    localparam int SLOT_W    = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NUM_DEST*CNT_W-1:0] cnt_flat;
    logic [NUM_DEST*SVC_W-1:0] svc_flat;
    logic [SLOT_W-1:0]         slot = SLOT_W'(NUM_SLOTS - 1);
    logic                      data_valid = 1'b0;
    logic                      hdr_valid;
    logic [HDR_W-1:0]          hdr;
    logic [CNT_W-1:0]          cnt_a [NUM_DEST];

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    always_comb begin
        for (int d = 0; d < NUM_DEST; d++) begin
            cnt_flat[d*CNT_W +: CNT_W] = cnt_a[d];
            svc_flat[d*SVC_W +: SVC_W] = SVC_W'(d + 1);
        end
    end

    prq_hdr_gen #(
        .NUM_DEST(NUM_DEST), .THRESHOLD(THRESHOLD), .NUM_SLOTS(NUM_SLOTS),
        .ARB_SLOT(ARB_SLOT), .NODE_ID(NODE_ID)
    ) i_prq_hdr_gen (
        .clk(clk), .rst(rst), .cnt_flat_i(cnt_flat), .svc_flat_i(svc_flat),
        .slot_i(slot), .data_valid_i(data_valid),
        .hdr_valid_o(hdr_valid), .hdr_o(hdr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_cnt(input int d, input int v);
        @(negedge clk);
        cnt_a[d] = CNT_W'(v);
    endtask

    task automatic clear_all();
        @(negedge clk);
        for (int d = 0; d < NUM_DEST; d++) cnt_a[d] = '0;
        @(negedge clk);
    endtask

    // Walk one full round-robin cycle and capture headers seen
    task automatic run_round(input logic dv, output int pulses, output prq_hdr_t h);
        pulses = 0;
        h = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            @(negedge clk);
            if (hdr_valid) begin pulses++; h = prq_hdr_t'(hdr); end
            slot = SLOT_W'(s);
            data_valid = dv;
        end
        @(negedge clk);
        if (hdr_valid) begin pulses++; h = prq_hdr_t'(hdr); end
        data_valid = 1'b0;
    endtask

    task automatic t_reset_idle();
        int p; prq_hdr_t h;
        chk("R1 hdr_valid after reset", int'(hdr_valid), 0);
        run_round(1'b0, p, h);
        chk("R5 one header per cycle", p, 1);
        chk("R1 no request after reset", int'(h.req), 0);
        chk("R7 idle dst", int'(h.dst), 0);
        chk("R7 idle volume", int'(h.vol), 0);
        chk("R6 placeholder when no data", int'(h.empty), 1);
        chk("R9 src field", int'(h.src), NODE_ID);
    endtask

    task automatic t_threshold();
        int p; prq_hdr_t h;
        set_cnt(1, THRESHOLD - 1);
        run_round(1'b1, p, h);
        chk("R3 below threshold no request", int'(h.req), 0);
        chk("R6 data cell not empty", int'(h.empty), 0);
        set_cnt(1, THRESHOLD);
        run_round(1'b1, p, h);
        chk("R2 request at threshold", int'(h.req), 1);
        chk("R2 dst", int'(h.dst), 1);
        chk("R9 volume", int'(h.vol), THRESHOLD);
        chk("R9 service type", int'(h.svc), 2);
    endtask

    task automatic t_rearm();
        int p; prq_hdr_t h;
        set_cnt(1, 20);
        run_round(1'b0, p, h);
        chk("R4 no repeat while above", int'(h.req), 0);
        set_cnt(1, 5);
        set_cnt(1, THRESHOLD);
        run_round(1'b0, p, h);
        chk("R4 rearmed request", int'(h.req), 1);
        chk("R4 rearmed dst", int'(h.dst), 1);
    endtask

    task automatic t_round_robin();
        int p; prq_hdr_t h;
        clear_all();
        set_cnt(0, 17);
        set_cnt(4, 30);
        set_cnt(5, 100);
        run_round(1'b0, p, h);
        chk("R8 first pick dst", int'(h.dst), 4);
        chk("R9 first pick volume", int'(h.vol), 30);
        run_round(1'b0, p, h);
        chk("R8 second pick dst", int'(h.dst), 5);
        chk("R9 second pick svc", int'(h.svc), 6);
        run_round(1'b0, p, h);
        chk("R8 wrap pick dst", int'(h.dst), 0);
        chk("R8 wrap pick volume", int'(h.vol), 17);
        run_round(1'b0, p, h);
        chk("R8 all served", int'(h.req), 0);
        clear_all();
    endtask

    task automatic t_withdraw();
        int p; prq_hdr_t h;
        set_cnt(3, THRESHOLD);
        @(negedge clk);
        set_cnt(3, 3);
        run_round(1'b0, p, h);
        chk("R10 withdrawn request", int'(h.req), 0);
        chk("R5 header still sent", p, 1);
    endtask

    task automatic t_long_slot();
        int p;
        p = 0;
        @(negedge clk);
        slot = SLOT_W'(ARB_SLOT);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (hdr_valid) p++;
        end
        slot = SLOT_W'(ARB_SLOT + 1);
        @(negedge clk);
        if (hdr_valid) p++;
        chk("R5 single pulse in long slot", p, 1);
    endtask

    initial begin
        for (int d = 0; d < NUM_DEST; d++) cnt_a[d] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_idle();
        t_threshold();
        t_rearm();
        t_round_robin();
        t_withdraw();
        t_long_slot();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule